// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Day Count and Alarm

This block keeps the time of day as two-digit BCD seconds, minutes and hours, plus a running 15-bit binary day number. A one-cycle pulse on `sec_tick` arrives once per second from an external prescaler. Each counted pulse advances the time. A rollover from 23:59:59 to 00:00:00 advances the day number.

Software reaches every field through a byte-wide register port with an 8-bit address. Writes are synchronous and reads are combinational. The register file holds:
- the three time registers;
- the day number, split over a low byte and a high byte;
- the alarm minute, alarm hour and alarm day;
- one control register with a run bit, three per-field alarm enables, an alarm interrupt enable, the alarm flag and a busy bit.

The alarm flag sets on the second where the time turns to seconds 00 and every enabled field matches its alarm value. The flag is cleared by writing a one to its bit. The interrupt output is the flag gated by the interrupt enable.

A counted tick opens a one-cycle busy window in which the counters update. A write that arrives in that window is not lost: it is held and applied in the cycle after busy drops.

Top module: `bcd_calendar`

## Requirements
- R1: After reset every register reads 0x00 and `alarm_irq` is 0.
- R2: The seconds register (0x15) counts 00 to 59 in BCD and returns to 00 after 59, which advances the minutes by one.
- R3: The minutes register (0x16) counts 00 to 59 in BCD and the hours register (0x17) counts 00 to 23 in BCD. Hours advance when minutes wrap, and the day advances when hours wrap from 23 to 00.
- R4: The day number is binary. Its bits 7:0 sit at 0x18 and its bits 14:8 at 0x19, where bit 7 reads 0. A carry from the low byte reaches the high byte, and 0x7FFF wraps to 0x0000.
- R5: While control bit 0 (run) is 0, ticks change no time or day register.
- R6: Control bit 7 (busy, read-only) reads 1 in the cycle after a counted tick is sampled. A write issued in that cycle takes effect one cycle after the time update and overrides it.
- R7: Control bit 2 (alarm flag) sets on the tick that makes seconds 00 while each enabled field equals its alarm register. Minute is enabled by bit 3 and compared with 0x1A. Hour is enabled by bit 4 and compared with 0x1B. Day is enabled by bit 5 and compared with 0x1C/0x1D. With a field enabled and not matching, the flag stays clear.
- R8: A field whose enable bit is 0 takes no part in the match.
- R9: Writing the control register with bit 2 at 1 clears the alarm flag. Writing it with bit 2 at 0 leaves the flag as it was.
- R10: `alarm_irq` is 1 exactly when the alarm flag is set and control bit 1 (interrupt enable) is 1.
- R11: The alarm registers 0x1A to 0x1D and control bits 5, 4, 3, 1 and 0 read back what was written. Control bit 6 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
Directed cases drive the time onto each carry boundary, and each case separates a wrong rollover point from a missing carry:
- 59 seconds into minutes;
- 23:59:59 into the next day;
- a day low byte of 0xFF into the high byte;
- a day number of 0x7FFF wrapping to zero.

Alarm cases set enabled fields that match and fields that do not match. They also leave a mismatching field disabled, which shows whether the enables gate the compare. The write-one and write-zero clears tell flag handling apart from plain register storage.

A write placed inside the busy window shows whether deferred writes are dropped or applied in the wrong order. Seeded random runs then mix times near rollover, random alarm settings and run on and off against a bench-side model.

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
  parameter int         DAY_W = 15,
  parameter logic [7:0] A_CTL = 8'h14,
  parameter logic [7:0] A_SEC = 8'h15,
  parameter logic [7:0] A_MIN = 8'h16,
  parameter logic [7:0] A_HR  = 8'h17,
  parameter logic [7:0] A_DLO = 8'h18,
  parameter logic [7:0] A_DHI = 8'h19,
  parameter logic [7:0] A_AMN = 8'h1A,
  parameter logic [7:0] A_AHR = 8'h1B,
  parameter logic [7:0] A_ADL = 8'h1C,
  parameter logic [7:0] A_ADH = 8'h1D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [7:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       alarm_irq
);
  localparam int DHI_W = DAY_W - 8;

  logic [7:0] sec_q, min_q, hour_q, amin_q, ahour_q;
  logic [DAY_W-1:0] day_q, aday_q;
  logic ctl_run, ctl_aien, ctl_men, ctl_hen, ctl_den, alm_flag, busy_q;
  logic pend_v;
  logic [7:0] pend_a, pend_d;
  logic eff_we;
  logic [7:0] eff_a, eff_d;
  logic [8:0] s_n, m_n, h_n;
  logic [7:0] sec_nx, min_nx, hr_nx;
  logic [DAY_W-1:0] day_nx;
  logic match;

  function automatic logic [8:0] bcd_step(input logic [7:0] v, input logic [7:0] top);
    if (v == top)            return {1'b1, 8'h00};
    else if (v[3:0] == 4'd9) return {1'b0, v[7:4] + 4'd1, 4'd0};
    else                     return {1'b0, v[7:4], v[3:0] + 4'd1};
  endfunction

  assign s_n    = bcd_step(sec_q, 8'h59);
  assign m_n    = bcd_step(min_q, 8'h59);
  assign h_n    = bcd_step(hour_q, 8'h23);
  assign sec_nx = s_n[7:0];
  assign min_nx = s_n[8] ? m_n[7:0] : min_q;
  assign hr_nx  = (s_n[8] & m_n[8]) ? h_n[7:0] : hour_q;
  assign day_nx = (s_n[8] & m_n[8] & h_n[8]) ? day_q + DAY_W'(1) : day_q;

  assign match = (sec_nx == 8'h00)
               && (!ctl_men || min_nx == amin_q)
               && (!ctl_hen || hr_nx  == ahour_q)
               && (!ctl_den || day_nx == aday_q);

  assign eff_we = !busy_q && (pend_v || reg_wr);
  assign eff_a  = pend_v ? pend_a : reg_addr;
  assign eff_d  = pend_v ? pend_d : reg_wdata;

  assign alarm_irq = alm_flag & ctl_aien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0; min_q <= '0; hour_q <= '0; day_q <= '0;
      amin_q <= '0; ahour_q <= '0; aday_q <= '0;
      ctl_run <= 1'b0; ctl_aien <= 1'b0; ctl_men <= 1'b0;
      ctl_hen <= 1'b0; ctl_den <= 1'b0; alm_flag <= 1'b0;
      busy_q <= 1'b0; pend_v <= 1'b0; pend_a <= '0; pend_d <= '0;
    end else begin
      busy_q <= sec_tick & ctl_run & ~busy_q;
      if (busy_q) begin
        if (reg_wr) begin
          pend_v <= 1'b1;
          pend_a <= reg_addr;
          pend_d <= reg_wdata;
        end
      end else begin
        pend_v <= pend_v & reg_wr;
        if (pend_v & reg_wr) begin
          pend_a <= reg_addr;
          pend_d <= reg_wdata;
        end
      end

      if (busy_q) begin
        sec_q  <= sec_nx;
        min_q  <= min_nx;
        hour_q <= hr_nx;
        day_q  <= day_nx;
        if (match) alm_flag <= 1'b1;
      end else if (eff_we) begin
        case (eff_a)
          A_SEC: sec_q  <= eff_d;
          A_MIN: min_q  <= eff_d;
          A_HR:  hour_q <= eff_d;
          A_DLO: day_q[7:0] <= eff_d;
          A_DHI: day_q[DAY_W-1:8] <= eff_d[DHI_W-1:0];
          A_AMN: amin_q  <= eff_d;
          A_AHR: ahour_q <= eff_d;
          A_ADL: aday_q[7:0] <= eff_d;
          A_ADH: aday_q[DAY_W-1:8] <= eff_d[DHI_W-1:0];
          A_CTL: begin
            ctl_run  <= eff_d[0];
            ctl_aien <= eff_d[1];
            ctl_men  <= eff_d[3];
            ctl_hen  <= eff_d[4];
            ctl_den  <= eff_d[5];
            if (eff_d[2]) alm_flag <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTL:   reg_rdata = {busy_q, 1'b0, ctl_den, ctl_hen, ctl_men, alm_flag, ctl_aien, ctl_run};
      A_SEC:   reg_rdata = sec_q;
      A_MIN:   reg_rdata = min_q;
      A_HR:    reg_rdata = hour_q;
      A_DLO:   reg_rdata = day_q[7:0];
      A_DHI:   reg_rdata = 8'(day_q[DAY_W-1:8]);
      A_AMN:   reg_rdata = amin_q;
      A_AHR:   reg_rdata = ahour_q;
      A_ADL:   reg_rdata = aday_q[7:0];
      A_ADH:   reg_rdata = 8'(aday_q[DAY_W-1:8]);
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

module bcd_calendar_chk #(
  parameter logic [7:0] A_SEC = 8'h15
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_tick,
  input logic       run,
  input logic       busy,
  input logic       eff_we,
  input logic [7:0] eff_a,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hour,
  input logic       flag
);
  assert_sec_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sec <= 8'h59 && sec[3:0] <= 4'd9);
  assert_hour_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hour <= 8'h23 && hour[3:0] <= 4'd9);
  assert_hour_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && sec == 8'h59 && min == 8'h59 && hour == 8'h23 |=> hour == 8'h00 && min == 8'h00);
  assert_sec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !(eff_we && eff_a == A_SEC) |=> $stable(sec));
  assert_busy_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && run && !busy |=> busy);
  assert_flag_sets_on_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !$rose(flag));
  assert_flag_zero_sec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> sec == 8'h00);
endmodule

bind bcd_calendar bcd_calendar_chk #(.A_SEC(A_SEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .run(ctl_run), .busy(busy_q),
  .eff_we(eff_we), .eff_a(eff_a), .sec(sec_q), .min(min_q), .hour(hour_q),
  .flag(alm_flag)
);

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0;
  logic [7:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic alarm_irq;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  bcd_calendar u_bcd_calendar (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alarm_irq(alarm_irq)
  );

  always #10 clk = ~clk;

  logic [7:0] m_sec, m_min, m_hour, m_amin, m_ahour, m_ctl;
  logic [14:0] m_day, m_aday;
  logic m_flag;

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] exp_ctl(input bit busy);
    return {busy, 1'b0, m_ctl[5:3], m_flag, m_ctl[1:0]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_write(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h15: m_sec = d;
      8'h16: m_min = d;
      8'h17: m_hour = d;
      8'h18: m_day[7:0] = d;
      8'h19: m_day[14:8] = d[6:0];
      8'h1A: m_amin = d;
      8'h1B: m_ahour = d;
      8'h1C: m_aday[7:0] = d;
      8'h1D: m_aday[14:8] = d[6:0];
      8'h14: begin m_ctl = d & 8'h3B; if (d[2]) m_flag = 1'b0; end
      default: ;
    endcase
  endtask

  task automatic m_tick();
    int s, mi, h;
    if (!m_ctl[0]) return;
    s = from_bcd(m_sec) + 1; mi = from_bcd(m_min); h = from_bcd(m_hour);
    if (s == 60) begin
      s = 0; mi++;
      if (mi == 60) begin
        mi = 0; h++;
        if (h == 24) begin h = 0; m_day = m_day + 15'd1; end
      end
    end
    m_sec = to_bcd(s); m_min = to_bcd(mi); m_hour = to_bcd(h);
    if (s == 0 && (!m_ctl[3] || m_min == m_amin) && (!m_ctl[4] || m_hour == m_ahour)
        && (!m_ctl[5] || m_day == m_aday))
      m_flag = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    m_write(a, d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    @(negedge clk);
    m_tick();
  endtask

  task automatic check_all(input string req);
    logic [7:0] v;
    rd(8'h15, v); check({req, " sec"}, 16'(v), 16'(m_sec));
    rd(8'h16, v); check({req, " min"}, 16'(v), 16'(m_min));
    rd(8'h17, v); check({req, " hour"}, 16'(v), 16'(m_hour));
    rd(8'h18, v); check({req, " daylo"}, 16'(v), 16'(m_day[7:0]));
    rd(8'h19, v); check({req, " dayhi"}, 16'(v), 16'({1'b0, m_day[14:8]}));
    rd(8'h14, v); check({req, " ctl"}, 16'(v), 16'(exp_ctl(1'b0)));
    check({req, " irq R10"}, 16'(alarm_irq), 16'(m_flag & m_ctl[1]));
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s,
                          input logic [14:0] d);
    wr(8'h15, s); wr(8'h16, mi); wr(8'h17, h);
    wr(8'h18, d[7:0]); wr(8'h19, {1'b0, d[14:8]});
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    m_sec = 0; m_min = 0; m_hour = 0; m_day = 0; m_amin = 0; m_ahour = 0; m_aday = 0;
    m_ctl = 0; m_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 8'h14; a <= 8'h1D; a++) begin
      rd(8'(a), v); check("R1 reset reg", 16'(v), 16'h0000);
    end
    check("R1 reset irq", 16'(alarm_irq), 16'h0000);

    // R11 readback
    wr(8'h1A, 8'h47); wr(8'h1B, 8'h19); wr(8'h1C, 8'hA5); wr(8'h1D, 8'hFF);
    wr(8'h14, 8'h7B);
    rd(8'h1A, v); check("R11 amin", 16'(v), 16'h47);
    rd(8'h1B, v); check("R11 ahour", 16'(v), 16'h19);
    rd(8'h1C, v); check("R11 adaylo", 16'(v), 16'hA5);
    rd(8'h1D, v); check("R11 adayhi bit7 zero", 16'(v), 16'h7F);
    rd(8'h14, v); check("R11 ctl", 16'(v), 16'(exp_ctl(1'b0)));
    wr(8'h14, 8'h00);

    // R5 run disabled
    set_time(8'h12, 8'h34, 8'h56, 15'h0123);
    repeat (3) tick();
    check_all("R5 hold");

    // R2 R3 R4 day wrap at 0x7FFF
    wr(8'h14, 8'h01);
    set_time(8'h23, 8'h59, 8'h58, 15'h7FFF);
    tick(); check_all("R2 to 59");
    tick(); check_all("R3 R4 wrap");
    check("R4 wrap to zero", 16'(m_day), 16'h0000);

    // R4 low-byte carry
    set_time(8'h23, 8'h59, 8'h59, 15'h00FF);
    tick(); check_all("R4 byte carry");
    rd(8'h19, v); check("R4 dayhi", 16'(v), 16'h01);
    set_time(8'h05, 8'h09, 8'h59, 15'h0010);
    tick(); check_all("R2 minute digit carry");

    // R6 busy and deferred write
    set_time(8'h01, 8'h02, 8'h03, 15'h0001);
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    rd(8'h14, v); check("R6 busy bit", 16'(v), 16'(exp_ctl(1'b1)));
    reg_addr = 8'h15; reg_wdata = 8'h30; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    m_tick();
    rd(8'h15, v); check("R6 update first", 16'(v), 16'h04);
    rd(8'h14, v); check("R6 busy clear", 16'(v[7]), 16'h0);
    @(negedge clk);
    m_write(8'h15, 8'h30);
    rd(8'h15, v); check("R6 deferred write", 16'(v), 16'h30);

    // R7 R10 full match
    wr(8'h14, 8'h00);
    set_time(8'h10, 8'h29, 8'h58, 15'h0005);
    wr(8'h1A, 8'h30); wr(8'h1B, 8'h10); wr(8'h1C, 8'h05); wr(8'h1D, 8'h00);
    wr(8'h14, 8'h3B);
    tick(); check_all("R7 before match");
    tick(); check_all("R7 match");
    check("R7 flag set", 16'(m_flag), 16'h1);
    check("R10 irq on", 16'(alarm_irq), 16'h1);
    wr(8'h14, 8'h39);
    check_all("R9 write zero keeps");
    check("R10 irq gated", 16'(alarm_irq), 16'h0);
    wr(8'h14, 8'h3F);
    check_all("R9 write one clears");

    // R7 mismatch on enabled hour
    wr(8'h1B, 8'h07);
    set_time(8'h10, 8'h29, 8'h59, 15'h0005);
    wr(8'h14, 8'h3B);
    tick(); check_all("R7 hour mismatch");
    check("R7 no flag", 16'(m_flag), 16'h0);

    // R8 hour disabled
    set_time(8'h10, 8'h29, 8'h59, 15'h0005);
    wr(8'h14, 8'h0B);
    tick(); check_all("R8 hour ignored");
    check("R8 flag", 16'(m_flag), 16'h1);
    wr(8'h14, 8'h0F);

    // random mix
    for (int it = 0; it < 150; it++) begin
      int k;
      k = $urandom_range(0, 5);
      if (k == 0) begin
        set_time(to_bcd($urandom_range(0, 23)), to_bcd($urandom_range(55, 59)),
                 to_bcd($urandom_range(57, 59)), 15'($urandom));
      end else if (k == 1) begin
        set_time(8'h23, 8'h59, to_bcd($urandom_range(56, 59)), 15'($urandom_range(32760, 32767)));
      end else if (k == 2) begin
        wr(8'h1A, (($urandom_range(0, 1)) != 0) ? to_bcd((from_bcd(m_min) + 1) % 60) : m_min);
        wr(8'h1B, (($urandom_range(0, 2)) != 0) ? m_hour : to_bcd($urandom_range(0, 23)));
        wr(8'h1C, m_day[7:0]);
        wr(8'h1D, {1'b0, m_day[14:8]});
      end else if (k == 3) begin
        wr(8'h14, 8'($urandom) | ((($urandom_range(0, 3)) != 0) ? 8'h01 : 8'h00));
      end
      repeat ($urandom_range(1, 4)) tick();
      check_all("R2 R3 R7 random");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule